// File: doc/BRIEF.md
# Register-Programmable Interrupt Controller

This block gathers a set of interrupt lines from peripherals and drives a single request line to a processor. Each line has its own latch. A line can be built as edge-captured, where the latch sets on a low-to-high transition and stays set, or as level-captured, where the latch sets on every cycle the line is high. Software reaches the block through eight 32-bit word registers. It selects a register with a 3-bit word index, writes on a write strobe and reads on a read strobe.

A latched event becomes pending only while its per-source enable bit is set. The request to the processor is raised only while a global request gate is open. Software turns individual enables on or off with dedicated set and clear aliases, so no read-modify-write is needed. It retires events by writing ones to an acknowledge register. A vector register names the pending source with the lowest index. Each source's capture style is fixed by a parameter when the block is built.

Top module: `irq_hub`

## Requirements
- R1: After a synchronous active-high reset, the latched status, the enable register and both master bits are zero, `cpu_irq` is low, and the vector reads 0xFFFFFFFF.
- R2: A write to the ENABLE register (index 1) replaces every enable bit with the written value. Writing zero masks all sources, so pending reads 0 and `cpu_irq` drops while status is kept.
- R3: The ACK register (index 5) is write-one-to-clear on status. Each 1 bit clears that source's latch, 0 bits leave their latches alone, and writing 0xFFFFFFFF clears every latch that is not being set again in the same cycle.
- R4: The CTRL register (index 0) holds two master bits. Bit 0 is the request gate: while it is 0, `cpu_irq` stays low. Bit 1 is the capture enable. Once bit 1 is written to 1 it stays set until reset. A read of CTRL returns both bits in positions 1:0.
- R5: The VECTOR register (index 4) reads 0xFFFFFFFF whenever no source is both latched and enabled.
- R6: A write to the ENSET register (index 6) sets the enable bits where the data is 1 and leaves the other enable bits unchanged.
- R7: A write to the ENCLR register (index 7) clears the enable bits where the data is 1 and leaves the other enable bits unchanged.
- R8: When some source is pending, VECTOR returns the lowest pending index, and that index is always below NUM_SRC.
- R9: The PENDING register (index 3) reads STATUS (index 2) AND ENABLE. `cpu_irq` is CTRL bit 0 AND the OR of all pending bits.
- R10: A source whose EDGE_MASK bit is 1 latches on a rising input while capture is on. It holds until acknowledged. A line that is still high does not re-latch after an acknowledge.
- R11: A source whose EDGE_MASK bit is 0 latches on every cycle its input is high while capture is on. An acknowledge given while the input is still high has no effect. Once the input is low, an acknowledge clears it.
- R12: While CTRL bit 1 is 0, input activity leaves every status bit unchanged.
- R13: Read data appears on `rd_data` one clock after the read strobe and holds until the next read. Reads of the write-only registers ACK, ENSET and ENCLR return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | NUM_SRC | Interrupt lines, synchronous to clk |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word index of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| cpu_irq | output | 1 | Request to the processor |

## Verification
The assertions assume that `src_in` is already synchronous to `clk`. They also assume that the write and read strobes carry a stable address and data for the whole cycle in which they are high. The bench changes every input only on the falling clock edge and pulses each strobe for exactly one cycle, so both assumptions hold. Because the bench never raises a source line in the same cycle as an acknowledge of that source, the priority between a new capture and a clear is covered only by the hold and level properties, not by a directed check.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int BUS_W = 32;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        RG_CTRL    = 3'd0,
        RG_ENABLE  = 3'd1,
        RG_STATUS  = 3'd2,
        RG_PENDING = 3'd3,
        RG_VECTOR  = 3'd4,
        RG_ACK     = 3'd5,
        RG_ENSET   = 3'd6,
        RG_ENCLR   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic cap_on;
        logic req_on;
    } master_t;

    typedef struct packed {
        logic             we;
        logic             re;
        reg_sel_e         sel;
        logic [BUS_W-1:0] wdata;
    } bus_req_t;

    localparam logic [BUS_W-1:0] VEC_NONE = '1;

    function automatic logic is_write_only(reg_sel_e s);
        return (s == RG_ACK) || (s == RG_ENSET) || (s == RG_ENCLR);
    endfunction

endpackage

// File: rtl/irq_capture.sv
module irq_capture
    import irq_hub_pkg::*;
#(
    parameter int                 N         = 8,
    parameter logic [N-1:0]       EDGE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_in,
    input  logic         cap_en,
    input  logic [N-1:0] ack_mask,
    output logic [N-1:0] stat_q
);

    logic [N-1:0] prev_q;
    logic [N-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= src_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            assign hit[i] = cap_en & src_in[i] & ~prev_q[i];
        end else begin : g_level
            assign hit[i] = cap_en & src_in[i];

            // R11: a high level line with capture on is latched next cycle
            p_level_sets_r11: assert property (@(posedge clk) disable iff (rst)
                (cap_en && src_in[i]) |=> stat_q[i]);
        end

        // R10: a latched event stays until its acknowledge bit is written
        p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (rst)
            (stat_q[i] && !ack_mask[i]) |=> stat_q[i]);

        // R12: no capture, no new latch
        p_no_capture_r12: assert property (@(posedge clk) disable iff (rst)
            (!cap_en && !stat_q[i]) |=> !stat_q[i]);
    end

    // A new capture wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= hit | (stat_q & ~ack_mask);
    end

endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import irq_hub_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     pend,
    output logic [BUS_W-1:0] vec,
    output logic             any
);

    localparam logic [N-1:0] ONE_N = N'(1);

    always_comb begin
        vec = VEC_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) vec = BUS_W'(i);
        end
    end

    assign any = |pend;

    // R5: idle vector
    p_idle_vector_r5: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> (vec == VEC_NONE));

    // R8: vector stays in range
    p_vec_range_r8: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |-> (vec < BUS_W'(N)));

    // R8: named source is pending and nothing lower is
    p_vec_lowest_r8: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |-> ((((pend >> vec) & ONE_N) == ONE_N) &&
                          ((pend & ((ONE_N << vec) - ONE_N)) == '0)));

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_hub_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [N-1:0]     stat_q,
    input  logic [N-1:0]     pend,
    input  logic [BUS_W-1:0] vec,
    output logic [N-1:0]     en_q,
    output master_t          mst_q,
    output logic [N-1:0]     ack_mask,
    output logic [BUS_W-1:0] rd_data
);

    logic [N-1:0]     wbits;
    logic [BUS_W-1:0] rd_mux;

    assign wbits    = req.wdata[N-1:0];
    assign ack_mask = (req.we && req.sel == RG_ACK) ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (req.we) begin
            case (req.sel)
                RG_ENABLE: en_q <= wbits;
                RG_ENSET:  en_q <= en_q | wbits;
                RG_ENCLR:  en_q <= en_q & ~wbits;
                default:   en_q <= en_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mst_q <= '0;
        end else if (req.we && req.sel == RG_CTRL) begin
            mst_q.req_on <= req.wdata[0];
            mst_q.cap_on <= mst_q.cap_on | req.wdata[1];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (!is_write_only(req.sel)) begin
            case (req.sel)
                RG_CTRL:    rd_mux[1:0]   = {mst_q.cap_on, mst_q.req_on};
                RG_ENABLE:  rd_mux[N-1:0] = en_q;
                RG_STATUS:  rd_mux[N-1:0] = stat_q;
                RG_PENDING: rd_mux[N-1:0] = pend;
                RG_VECTOR:  rd_mux        = vec;
                default:    rd_mux        = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (req.re) rd_data <= rd_mux;
    end

    // R4: capture enable is sticky
    p_cap_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        mst_q.cap_on |=> mst_q.cap_on);

    // R6: set alias turns on the written bits
    p_enset_r6: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.sel == RG_ENSET) |=> ((en_q & $past(wbits)) == $past(wbits)));

    // R7: clear alias turns off the written bits
    p_enclr_r7: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.sel == RG_ENCLR) |=> ((en_q & $past(wbits)) == '0));

    // R7: clear alias never turns a bit on
    p_enclr_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.sel == RG_ENCLR) |=> ((en_q & ~$past(en_q)) == '0));

    // R13: read data holds without a read strobe
    p_rd_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !req.re |=> $stable(rd_data));

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int                  NUM_SRC   = 8,
    parameter logic [NUM_SRC-1:0]  EDGE_MASK = NUM_SRC'(8'h0F)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [SEL_W-1:0]   addr,
    input  logic [BUS_W-1:0]   wr_data,
    output logic [BUS_W-1:0]   rd_data,
    output logic               cpu_irq
);

    bus_req_t           req;
    master_t            mst_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ack_mask;
    logic [BUS_W-1:0]   vec;
    logic               any;

    assign req.we    = wr_en;
    assign req.re    = rd_en;
    assign req.sel   = reg_sel_e'(addr);
    assign req.wdata = wr_data;

    irq_capture #(.N(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .src_in   (src_in),
        .cap_en   (mst_q.cap_on),
        .ack_mask (ack_mask),
        .stat_q   (stat_q)
    );

    assign pend = stat_q & en_q;

    irq_prio #(.N(NUM_SRC)) u_prio (
        .clk  (clk),
        .rst  (rst),
        .pend (pend),
        .vec  (vec),
        .any  (any)
    );

    irq_regs #(.N(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .stat_q   (stat_q),
        .pend     (pend),
        .vec      (vec),
        .en_q     (en_q),
        .mst_q    (mst_q),
        .ack_mask (ack_mask),
        .rd_data  (rd_data)
    );

    assign cpu_irq = mst_q.req_on & any;

    // R4: closed request gate keeps the line low
    p_irq_gate_r4: assert property (@(posedge clk) disable iff (rst)
        !mst_q.req_on |-> !cpu_irq);

    // R2: with every enable off there is no request
    p_no_enable_r2: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !cpu_irq);

endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;
    import irq_hub_pkg::*;

    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  src_in;
    logic          wr_en, rd_en;
    logic [2:0]    addr;
    logic [31:0]   wr_data;
    logic [31:0]   rd_data;
    logic          cpu_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_hub #(.NUM_SRC(N), .EDGE_MASK(8'h0F)) uut (
        .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .cpu_irq(cpu_irq)
    );

    typedef struct packed {
        logic        is_rd;
        logic [2:0]  a;
        logic [31:0] d;
        logic [7:0]  rq;
    } step_t;

    // Register-only walk; for reads d is the expected value
    localparam int NSTEP = 15;
    localparam step_t TBL [NSTEP] = '{
        '{1'b1, 3'd2, 32'h0000_0000, 8'd1},   // R1 status
        '{1'b1, 3'd1, 32'h0000_0000, 8'd1},   // R1 enable
        '{1'b1, 3'd0, 32'h0000_0000, 8'd1},   // R1 ctrl
        '{1'b1, 3'd4, 32'hFFFF_FFFF, 8'd5},   // R5 idle vector
        '{1'b0, 3'd1, 32'h0000_00A5, 8'd2},
        '{1'b1, 3'd1, 32'h0000_00A5, 8'd2},   // R2
        '{1'b0, 3'd6, 32'h0000_0002, 8'd6},
        '{1'b1, 3'd1, 32'h0000_00A7, 8'd6},   // R6
        '{1'b0, 3'd7, 32'h0000_0081, 8'd7},
        '{1'b1, 3'd1, 32'h0000_0026, 8'd7},   // R7
        '{1'b0, 3'd0, 32'h0000_0003, 8'd4},
        '{1'b1, 3'd0, 32'h0000_0003, 8'd4},   // R4
        '{1'b0, 3'd0, 32'h0000_0001, 8'd4},
        '{1'b1, 3'd0, 32'h0000_0003, 8'd4},   // R4 sticky bit 1
        '{1'b1, 3'd5, 32'h0000_0000, 8'd13}   // R13 write-only reads 0
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        src_in[idx] = 1'b1;
        @(negedge clk);
        src_in[idx] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; src_in = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
        do_reset();
        chk("R1 cpu_irq after reset", {31'b0, cpu_irq}, 32'h0);

        for (int k = 0; k < NSTEP; k++) begin
            if (TBL[k].is_rd) begin
                rd(TBL[k].a, v);
                chk($sformatf("R%0d table step %0d", TBL[k].rq, k), v, TBL[k].d);
            end else begin
                wr(TBL[k].a, TBL[k].d);
            end
        end

        // R10 edge capture, R8 vector, R9 pending and request
        wr(3'd1, 32'hFF);
        pulse(2);
        rd_chk("R10 status after edge on 2", 3'd2, 32'h04);
        rd_chk("R9 pending", 3'd3, 32'h04);
        rd_chk("R8 vector 2", 3'd4, 32'd2);
        chk("R9 cpu_irq high", {31'b0, cpu_irq}, 32'h1);
        pulse(1);
        rd_chk("R10 status both", 3'd2, 32'h06);
        rd_chk("R8 lowest wins", 3'd4, 32'd1);

        // R3 acknowledge one bit
        wr(3'd5, 32'h02);
        rd_chk("R3 ack clears bit 1 only", 3'd2, 32'h04);
        rd_chk("R8 vector back to 2", 3'd4, 32'd2);

        // R2 enable zero masks everything
        wr(3'd1, 32'h0);
        chk("R2 cpu_irq masked", {31'b0, cpu_irq}, 32'h0);
        rd_chk("R2 pending zero", 3'd3, 32'h0);
        rd_chk("R5 vector idle", 3'd4, 32'hFFFF_FFFF);
        rd_chk("R2 status kept", 3'd2, 32'h04);

        // R4 request gate
        wr(3'd1, 32'hFF);
        wr(3'd0, 32'h2);
        chk("R4 gate closed", {31'b0, cpu_irq}, 32'h0);
        rd_chk("R4 ctrl reads 2", 3'd0, 32'h2);
        wr(3'd0, 32'h1);
        chk("R4 gate open", {31'b0, cpu_irq}, 32'h1);
        rd_chk("R4 capture stays on", 3'd0, 32'h3);

        // R11 level source 5
        @(negedge clk); src_in[5] = 1'b1;
        @(negedge clk);
        rd_chk("R11 level latched", 3'd2, 32'h24);
        wr(3'd5, 32'h20);
        rd_chk("R11 ack while high ignored", 3'd2, 32'h24);
        @(negedge clk); src_in[5] = 1'b0;
        wr(3'd5, 32'h20);
        rd_chk("R11 ack after low clears", 3'd2, 32'h04);

        // R10 edge source held high does not re-latch
        @(negedge clk); src_in[0] = 1'b1;
        @(negedge clk);
        rd_chk("R10 edge 0 latched", 3'd2, 32'h05);
        wr(3'd5, 32'h01);
        rd_chk("R10 no re-latch while high", 3'd2, 32'h04);
        wr(3'd5, 32'hFFFF_FFFF);
        rd_chk("R3 ack all ones", 3'd2, 32'h0);
        rd_chk("R5 vector after clear", 3'd4, 32'hFFFF_FFFF);
        chk("R9 cpu_irq low after clear", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk); src_in[0] = 1'b0;

        // R1 second reset, then R12 capture off
        wr(3'd1, 32'hFF);
        do_reset();
        chk("R1 cpu_irq after second reset", {31'b0, cpu_irq}, 32'h0);
        rd_chk("R1 ctrl cleared", 3'd0, 32'h0);
        rd_chk("R1 enable cleared", 3'd1, 32'h0);
        wr(3'd1, 32'hFF);
        wr(3'd0, 32'h1);
        pulse(3);
        @(negedge clk); src_in[6] = 1'b1;
        repeat (2) @(negedge clk);
        rd_chk("R12 no capture", 3'd2, 32'h0);
        chk("R12 cpu_irq low", {31'b0, cpu_irq}, 32'h0);
        src_in[6] = 1'b0;
        wr(3'd0, 32'h3);
        @(negedge clk); src_in[6] = 1'b1;
        @(negedge clk); src_in[6] = 1'b0;
        rd_chk("R11 level 6 after capture on", 3'd2, 32'h40);
        rd_chk("R8 vector 6", 3'd4, 32'd6);
        rd_chk("R13 write-only ENSET reads 0", 3'd6, 32'h0);
        chk("R13 read data holds", rd_data, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule